// File: doc/BRIEF.md
# Multi-Mode Effective Address Sequencer

This block forms the effective address of an operand. It takes a mode code, the value of a base register, the value of an index register, the program counter, two signed displacements, an index scale code and an operand size code. It then produces a 32-bit address together with a one-cycle completion strobe. Modes that do not touch memory finish in a single cycle. They cover immediate, register indirect, predecrement, base plus displacement plus scaled index, and PC-relative indexed.

Three memory-indirect modes first fetch a pointer through a request/valid read port and then finish the address from that pointer. They differ only in where the scaled index goes. It is added after the fetch in post-indexed mode and before the fetch in pre-indexed mode.

In predecrement mode the block also raises a write-back request. That request carries the decremented base value so the register file can update the base register. Instruction decoding, the register file and the operand fetch itself sit outside this block.

Top module: `ea_sequencer`

## Requirements
- R1: After reset, `done`, `mem_req` and `wb_valid` are low.
- R2: Mode code 0 (immediate) returns the sign-extended `disp1` on `ea`, with `done` high in the cycle after `start` is sampled.
- R3: Mode code 1 (register indirect) returns `base_val` on `ea` one cycle after `start`.
- R4: Mode code 2 (predecrement) returns `base_val` minus the operand size on `ea` one cycle after `start`. The size codes are 0→1, 1→2, 2→4 and 3→4. In the same cycle as `done`, `wb_valid` is high and `wb_value` equals `ea`.
- R5: Mode code 3 (indexed) returns `base_val` + sext(`disp1`) + `index_val`×scale one cycle after `start`. The scale codes are 0→1, 1→2, 2→4 and 3→4.
- R6: Mode code 7 (PC-relative indexed) returns `pc_val` + sext(`disp1`) + `index_val`×scale one cycle after `start`.
- R7: Mode code 4 (memory indirect) raises `mem_req` in the cycle after `start`, with `mem_addr` = `base_val` + sext(`disp1`). The request and address are held until `mem_valid`. The result is `mem_rdata` + sext(`disp2`).
- R8: Mode code 5 (post-indexed) reads at `base_val` + sext(`disp1`). The result is `mem_rdata` + sext(`disp2`) + `index_val`×scale.
- R9: Mode code 6 (pre-indexed) reads at `base_val` + sext(`disp1`) + `index_val`×scale. The result is `mem_rdata` + sext(`disp2`).
- R10: For an indirect mode, `done` is high in the cycle after `mem_valid` is sampled with `mem_req` high, and `mem_req` drops in that cycle. `done` is always a single-cycle pulse.
- R11: A `start` while a fetch is outstanding leaves `mem_addr`, `mem_req` and the final result unchanged. A `mem_valid` while idle produces no `done`.
- R12: Displacements are sign-extended to 32 bits, and all sums and differences wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an address calculation |
| mode | input | 3 | Addressing mode code |
| size_sel | input | 2 | Operand size code for predecrement |
| scale_sel | input | 2 | Index scale code |
| base_val | input | ADDR_W | Base register value |
| index_val | input | ADDR_W | Index register value |
| pc_val | input | ADDR_W | Program counter value |
| disp1 | input | DISP_W | First signed displacement |
| disp2 | input | DISP_W | Second signed displacement (after pointer fetch) |
| mem_req | output | 1 | Pointer read request, held until `mem_valid` |
| mem_addr | output | ADDR_W | Pointer read address |
| mem_valid | input | 1 | Pointer read data valid |
| mem_rdata | input | ADDR_W | Pointer read data |
| done | output | 1 | One-cycle completion strobe |
| ea | output | ADDR_W | Effective address, valid with `done` |
| wb_valid | output | 1 | Base register write-back request |
| wb_value | output | ADDR_W | Updated base register value |

## Verification
The bench builds the block with its defaults: 32-bit addresses and 16-bit displacements. With these widths, negative displacements exercise the sign extension. Bases near zero or near 2^32 exercise wrap-around of both the decrement and the three-term sum. The memory side is driven by the bench. It returns data after zero, two or three wait cycles, which exercises the held request and the rejection of a `start` arriving mid-fetch.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [2:0] {
        EA_IMM     = 3'd0,
        EA_RIND    = 3'd1,
        EA_PREDEC  = 3'd2,
        EA_INDEXED = 3'd3,
        EA_MEMIND  = 3'd4,
        EA_POSTIDX = 3'd5,
        EA_PREIDX  = 3'd6,
        EA_PCREL   = 3'd7
    } ea_mode_e;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } ea_state_e;

    // Size and scale codes share one mapping: 0->x1, 1->x2, 2/3->x4.
    function automatic logic [1:0] code_to_shift(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

endpackage

// File: rtl/ea_sext.sv
module ea_sext #(
    parameter int DISP_W = 16,
    parameter int ADDR_W = 32
) (
    input  logic [DISP_W-1:0] din,
    output logic [ADDR_W-1:0] dout
);
    generate
        if (DISP_W >= ADDR_W) begin : g_trunc
            assign dout = din[ADDR_W-1:0];
        end else begin : g_extend
            localparam int PAD_W = ADDR_W - DISP_W;
            assign dout = {{PAD_W{din[DISP_W-1]}}, din};
        end
    endgenerate
endmodule

// File: rtl/ea_scale.sv
module ea_scale #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] idx,
    input  logic [1:0]        sel,
    output logic [ADDR_W-1:0] scaled
);
    import ea_pkg::*;

    assign scaled = idx << code_to_shift(sel);
endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [1:0]        size_sel,
    input  logic [1:0]        scale_sel,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    input  logic [ADDR_W-1:0] pc_val,
    input  logic [DISP_W-1:0] disp1,
    input  logic [DISP_W-1:0] disp2,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              done,
    output logic [ADDR_W-1:0] ea,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_value
);
    import ea_pkg::*;

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    typedef struct packed {
        ea_state_e         st;
        logic              done;
        logic              wb;
        logic              req;
        logic [ADDR_W-1:0] ea;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] tail;
    } seq_regs_t;

    seq_regs_t regs_q, regs_d;

    logic [ADDR_W-1:0] d1_ext, d2_ext, idx_scaled, op_size;

    ea_sext #(.DISP_W(DISP_W), .ADDR_W(ADDR_W)) u_sext1 (.din(disp1), .dout(d1_ext));
    ea_sext #(.DISP_W(DISP_W), .ADDR_W(ADDR_W)) u_sext2 (.din(disp2), .dout(d2_ext));
    ea_scale #(.ADDR_W(ADDR_W)) u_scale (.idx(index_val), .sel(scale_sel), .scaled(idx_scaled));

    assign op_size = ONE << code_to_shift(size_sel);

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        regs_d.wb   = 1'b0;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (start) begin
                    unique case (ea_mode_e'(mode))
                        EA_IMM: begin
                            regs_d.ea   = d1_ext;
                            regs_d.done = 1'b1;
                        end
                        EA_RIND: begin
                            regs_d.ea   = base_val;
                            regs_d.done = 1'b1;
                        end
                        EA_PREDEC: begin
                            regs_d.ea   = base_val - op_size;
                            regs_d.done = 1'b1;
                            regs_d.wb   = 1'b1;
                        end
                        EA_INDEXED: begin
                            regs_d.ea   = base_val + d1_ext + idx_scaled;
                            regs_d.done = 1'b1;
                        end
                        EA_PCREL: begin
                            regs_d.ea   = pc_val + d1_ext + idx_scaled;
                            regs_d.done = 1'b1;
                        end
                        EA_MEMIND: begin
                            regs_d.st   = ST_FETCH;
                            regs_d.req  = 1'b1;
                            regs_d.addr = base_val + d1_ext;
                            regs_d.tail = d2_ext;
                        end
                        EA_POSTIDX: begin
                            regs_d.st   = ST_FETCH;
                            regs_d.req  = 1'b1;
                            regs_d.addr = base_val + d1_ext;
                            regs_d.tail = d2_ext + idx_scaled;
                        end
                        EA_PREIDX: begin
                            regs_d.st   = ST_FETCH;
                            regs_d.req  = 1'b1;
                            regs_d.addr = base_val + d1_ext + idx_scaled;
                            regs_d.tail = d2_ext;
                        end
                        default: ;
                    endcase
                end
            end
            ST_FETCH: begin
                if (mem_valid) begin
                    regs_d.st   = ST_IDLE;
                    regs_d.req  = 1'b0;
                    regs_d.ea   = mem_rdata + regs_q.tail;
                    regs_d.done = 1'b1;
                end
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign mem_req  = regs_q.req;
    assign mem_addr = regs_q.addr;
    assign done     = regs_q.done;
    assign ea       = regs_q.ea;
    assign wb_valid = regs_q.wb;
    assign wb_value = regs_q.ea;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // R10
    fetch_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid) |=> (done && !mem_req));

    // R4
    wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (done && wb_value == ea));

    // R11
    idle_valid_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && !start && mem_valid) |=> !done);

    // R10
    no_done_while_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> !done);

endmodule

// File: tb/ea_sequencer_tb.sv
`timescale 1ns/1ps
module ea_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  size_sel = '0;
    logic [1:0]  scale_sel = '0;
    logic [31:0] base_val = '0;
    logic [31:0] index_val = '0;
    logic [31:0] pc_val = '0;
    logic [15:0] disp1 = '0;
    logic [15:0] disp2 = '0;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_req, done, wb_valid;
    logic [31:0] mem_addr, ea, wb_value;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ea_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .size_sel(size_sel), .scale_sel(scale_sel), .base_val(base_val),
        .index_val(index_val), .pc_val(pc_val), .disp1(disp1), .disp2(disp2),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .done(done), .ea(ea), .wb_valid(wb_valid),
        .wb_value(wb_value)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] m, input logic [1:0] sz, input logic [1:0] sc,
                         input logic [31:0] b, input logic [31:0] ix, input logic [31:0] p,
                         input logic [15:0] a1, input logic [15:0] a2);
        mode = m; size_sel = sz; scale_sel = sc; base_val = b;
        index_val = ix; pc_val = p; disp1 = a1; disp2 = a2;
    endtask

    task automatic run_direct(input logic [2:0] m, input logic [1:0] sz, input logic [1:0] sc,
                              input logic [31:0] b, input logic [31:0] ix, input logic [31:0] p,
                              input logic [15:0] a1, input logic [31:0] exp_ea, input bit exp_wb,
                              input string req);
        @(negedge clk);
        drive(m, sz, sc, b, ix, p, a1, 16'h0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, req, {31'b0, done}, 32'd1);
        chk(ea == exp_ea, req, ea, exp_ea);
        chk(wb_valid == exp_wb, req, {31'b0, wb_valid}, {31'b0, exp_wb});
        if (exp_wb) chk(wb_value == exp_ea, req, wb_value, exp_ea);
        @(negedge clk);
        chk(done == 1'b0, "R10", {31'b0, done}, 32'd0);
    endtask

    task automatic run_indirect(input logic [2:0] m, input logic [1:0] sc,
                                input logic [31:0] b, input logic [31:0] ix,
                                input logic [15:0] a1, input logic [15:0] a2,
                                input logic [31:0] exp_addr, input logic [31:0] rdata,
                                input int waitc, input bit poke,
                                input logic [31:0] exp_ea, input string req);
        @(negedge clk);
        drive(m, 2'd0, sc, b, ix, 32'h0, a1, a2);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(mem_req == 1'b1, req, {31'b0, mem_req}, 32'd1);
        chk(mem_addr == exp_addr, req, mem_addr, exp_addr);
        for (int i = 0; i < waitc; i++) begin
            if (poke) begin
                drive(3'd0, 2'd0, 2'd0, 32'h5555_0000, 32'h0, 32'h0, 16'h1234, 16'h0);
                start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            chk(mem_req == 1'b1, "R7", {31'b0, mem_req}, 32'd1);
            chk(mem_addr == exp_addr, poke ? "R11" : "R7", mem_addr, exp_addr);
            chk(done == 1'b0, poke ? "R11" : "R10", {31'b0, done}, 32'd0);
        end
        mem_valid = 1'b1;
        mem_rdata = rdata;
        @(negedge clk);
        mem_valid = 1'b0;
        chk(done == 1'b1, "R10", {31'b0, done}, 32'd1);
        chk(ea == exp_ea, req, ea, exp_ea);
        chk(mem_req == 1'b0, "R10", {31'b0, mem_req}, 32'd0);
        @(negedge clk);
        chk(done == 1'b0, "R10", {31'b0, done}, 32'd0);
    endtask

    task automatic test_reset();
        chk(done == 1'b0, "R1", {31'b0, done}, 32'd0);
        chk(mem_req == 1'b0, "R1", {31'b0, mem_req}, 32'd0);
        chk(wb_valid == 1'b0, "R1", {31'b0, wb_valid}, 32'd0);
    endtask

    task automatic test_idle_valid();
        @(negedge clk);
        mem_valid = 1'b1;
        mem_rdata = 32'hDEAD_BEEF;
        @(negedge clk);
        mem_valid = 1'b0;
        chk(done == 1'b0, "R11", {31'b0, done}, 32'd0);
        chk(mem_req == 1'b0, "R11", {31'b0, mem_req}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        // R2 immediate with negative displacement, R12 sign extension
        run_direct(3'd0, 2'd0, 2'd0, 32'h0, 32'h0, 32'h0, 16'hFF80, 32'hFFFF_FF80, 1'b0, "R2");
        // R3 register indirect
        run_direct(3'd1, 2'd0, 2'd0, 32'h1000_0040, 32'h0, 32'h0, 16'h0, 32'h1000_0040, 1'b0, "R3");
        // R4 predecrement with each size code
        run_direct(3'd2, 2'd0, 2'd0, 32'h2000, 32'h0, 32'h0, 16'h0, 32'h1FFF, 1'b1, "R4");
        run_direct(3'd2, 2'd2, 2'd0, 32'h2000, 32'h0, 32'h0, 16'h0, 32'h1FFC, 1'b1, "R4");
        run_direct(3'd2, 2'd3, 2'd0, 32'h2000, 32'h0, 32'h0, 16'h0, 32'h1FFC, 1'b1, "R4");
        // R12 predecrement wrap below zero
        run_direct(3'd2, 2'd1, 2'd0, 32'h0, 32'h0, 32'h0, 16'h0, 32'hFFFF_FFFE, 1'b1, "R12");
        // R5 indexed with each scale code
        run_direct(3'd3, 2'd0, 2'd0, 32'h100, 32'd3, 32'h0, 16'h8, 32'h10B, 1'b0, "R5");
        run_direct(3'd3, 2'd0, 2'd1, 32'h100, 32'd3, 32'h0, 16'h8, 32'h10E, 1'b0, "R5");
        run_direct(3'd3, 2'd0, 2'd2, 32'h100, 32'd3, 32'h0, 16'h8, 32'h114, 1'b0, "R5");
        run_direct(3'd3, 2'd0, 2'd3, 32'h100, 32'd3, 32'h0, 16'h8, 32'h114, 1'b0, "R5");
        // R12 sum wraps past 2^32
        run_direct(3'd3, 2'd0, 2'd0, 32'hFFFF_FFF0, 32'h0, 32'h0, 16'h0020, 32'h10, 1'b0, "R12");
        // R6 PC-relative table access
        run_direct(3'd7, 2'd0, 2'd2, 32'h0, 32'd2, 32'h4000, 16'hFFFC, 32'h4004, 1'b0, "R6");
        // R7 memory indirect, no wait
        run_indirect(3'd4, 2'd0, 32'h8000, 32'h0, 16'h10, 16'hFFF8, 32'h8010,
                     32'hA000, 0, 1'b0, 32'h9FF8, "R7");
        // R8 post-indexed, with start pokes while busy (R11)
        run_indirect(3'd5, 2'd2, 32'h8000, 32'd5, 16'h4, 16'h10, 32'h8004,
                     32'h2000, 3, 1'b1, 32'h2024, "R8");
        // R9 pre-indexed
        run_indirect(3'd6, 2'd2, 32'h8000, 32'd5, 16'h4, 16'h10, 32'h8018,
                     32'h3000, 2, 1'b0, 32'h3010, "R9");
        test_idle_valid();
        // R3 block accepts a new start after an indirect sequence
        run_direct(3'd1, 2'd0, 2'd0, 32'hCAFE_0000, 32'h0, 32'h0, 16'h0, 32'hCAFE_0000, 1'b0, "R3");
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule